// File: doc/BRIEF.md
# EPROM Byte Program-and-Verify Sequencer

This block writes a run of bytes into an ultraviolet-erasable or one-time-programmable EPROM over a parallel address and data interface, then reads locations back to confirm them. A host gives a start address, a byte count and an operation code, pulses `start`, and then supplies bytes over a valid/ready stream. For each location the sequencer presents the address and data, waits a setup interval, raises the programming-voltage enable, gives exactly one program strobe of a fixed length, waits a hold interval and drops the voltage again. It then releases its data drivers and turns on the memory's output enable to read the byte back. The analog supply switching is outside the block. Pulse and setup lengths are cycle counts set by parameters.

Four operations exist. Program-and-verify checks each byte right after its pulse. Program-only writes without reading back. Verify compares the memory against a streamed copy of the data, so a whole programmed range can be checked again in one pass. Blank check expects every location to read as erased. Every read-back gives a one-cycle result carrying the address and a pass bit. A mismatch sets a sticky error flag and stores the first failing address. It ends the run unless continue-on-error was set when the run began.

The state machine has these states: IDLE, LOAD (wait for a stream byte), ADDR_SET (address and data driven), VPP_UP (voltage enable raised), PULSE (strobe low), VPP_HOLD (strobe released, voltage still up), VPP_DOWN (voltage released, data still driven), RD_REL (data drivers released), RD_WAIT (output enable on, sample on the last cycle), CHECK (result) and DONE.

Its transitions are as follows:
- IDLE or DONE with `start`: a zero count goes to DONE, blank check goes to RD_REL, and the other operations go to LOAD.
- LOAD on a handshake: verify goes to RD_REL, the programming operations go to ADDR_SET.
- ADDR_SET, VPP_UP, PULSE, VPP_HOLD, RD_REL and RD_WAIT each pass to the next state when their timer expires.
- VPP_DOWN: program-only goes to LOAD, or to DONE on the last byte. The other operations go to RD_REL.
- CHECK: a stopping mismatch or the last byte goes to DONE. Otherwise blank check goes to RD_REL and the other operations go to LOAD.

Top module: `eprom_pgm_seq`

## Requirements
- R1: While a byte is programmed, `mem_addr` and `mem_dout` are steady for at least SETUP_CYC cycles before `vpp_en` rises and do not change until `vpp_en` has fallen. `vpp_en` rises at least SETUP_CYC cycles before `prog_n` falls, falls at least SETUP_CYC cycles after `prog_n` rises, and changes only while `prog_n` is high.
- R2: Each programmed byte gets exactly one low pulse on `prog_n`, lasting exactly PULSE_CYC cycles. `prog_n` is low only while `vpp_en`, `mem_dout_en` and `mode_en` are high.
- R3: On a read-back, `mem_dout_en` is low for at least SETUP_CYC cycles before `oe_n` goes low. `oe_n` is low for SETUP_CYC cycles, only while `mem_dout_en` is low, and `mem_din` is sampled in its last low cycle.
- R4: Each read-back produces exactly one cycle of `res_valid`, with `res_addr` set to the location and `res_pass` high exactly when the byte read equals the expected byte.
- R5: `op_mode` selects the operation. 2'b00 is program then verify each byte. 2'b01 is program only: `oe_n` never goes low and no results are produced. 2'b10 is verify against streamed bytes with no strobe. 2'b11 is blank check, which expects 8'hFF, takes no stream and gives no strobe.
- R6: Locations are processed in the order base, base+1, and so on, wrapping modulo 2^AW, for `byte_count` locations. A count of zero goes straight to done with no strobe and no result.
- R7: A mismatch sets `err_flag` and stores the first failing address in `err_addr`. Both hold until the next accepted start, which clears them.
- R8: If `cont_on_err` was low at start, the run stops at DONE in the cycle after the first failing result, with no further strobes or results. If it was high, all locations are processed.
- R9: `done` rises when a run ends and stays high until the next start. A `start` pulse while a run is in progress is ignored.
- R10: After reset: `prog_n`=1, `oe_n`=1, `vpp_en`=0, `mem_dout_en`=0, `mode_en`=0, `in_ready`=0, `res_valid`=0, `done`=0, `err_flag`=0.
- R11: In modes 2'b00, 2'b01 and 2'b10 exactly one stream byte is taken per location, and `in_ready` is high only while waiting for it. In mode 2'b11 `in_ready` stays low.
- R12: `mode_en` is high from the cycle after an accepted start until `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in IDLE or DONE) |
| op_mode | input | 2 | Operation code, see R5 |
| base_addr | input | AW | First location |
| byte_count | input | AW+1 | Number of locations |
| cont_on_err | input | 1 | Keep going after a mismatch |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | DW | Stream byte |
| in_ready | output | 1 | Stream byte accepted when valid |
| mem_addr | output | AW | EPROM address bus |
| mem_dout | output | DW | Data driven to the EPROM |
| mem_dout_en | output | 1 | Data drivers on |
| mem_din | input | DW | Data read from the EPROM |
| mode_en | output | 1 | Programming/verify control combination active |
| vpp_en | output | 1 | Programming-voltage enable |
| prog_n | output | 1 | Active-low program strobe |
| oe_n | output | 1 | Active-low memory output enable |
| res_valid | output | 1 | Read-back result valid |
| res_pass | output | 1 | Read-back matched |
| res_addr | output | AW | Location of the result |
| done | output | 1 | Run finished |
| err_flag | output | 1 | Sticky mismatch flag |
| err_addr | output | AW | First failing location |

## Verification
The collision of interest is a failing compare on the final location. In the CHECK cycle, the stop-on-error path and the normal end of the count both want to move to DONE. The bench drives it with a read fault placed on the last address of a two-byte run, once with continue-on-error low and once with it high. It then checks that exactly two results appear, the second failing, that `done` follows at once with no extra strobe, and that `err_addr` holds the last address. A behavioural EPROM model in the bench measures every voltage, strobe and output-enable edge against the setup, hold and pulse counts, and only accepts a write after a complete pulse.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ADDR_SET,
        ST_VPP_UP,
        ST_PULSE,
        ST_VPP_HOLD,
        ST_VPP_DOWN,
        ST_RD_REL,
        ST_RD_WAIT,
        ST_CHECK,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG_VERIFY = 2'b00,
        OP_PROG_ONLY   = 2'b01,
        OP_VERIFY      = 2'b10,
        OP_BLANK       = 2'b11
    } seq_op_t;

endpackage

// File: rtl/eprom_step_timer.sv
module eprom_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // limit is the number of cycles spent in the current state
    assign expired = (cnt == (limit - 1'b1));
endmodule

// File: rtl/eprom_span_ctr.sv
module eprom_span_ctr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   count,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= base;
            remain <= count;
        end else if (step) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == {{AW{1'b0}}, 1'b1});
endmodule

// File: rtl/eprom_read_check.sv
module eprom_read_check #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    input  logic [DW-1:0] expect_byte,
    output logic          match
);
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_q <= '0;
        else if (capture) rd_q <= bus_in;
    end

    assign match = (rd_q == expect_byte);
endmodule

// File: rtl/eprom_pgm_seq.sv
module eprom_pgm_seq
    import eprom_seq_pkg::*;
#(
    parameter int AW        = 13,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 5000,
    parameter int SETUP_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_mode,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   byte_count,
    input  logic          cont_on_err,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    output logic          mode_en,
    output logic          vpp_en,
    output logic          prog_n,
    output logic          oe_n,
    output logic          res_valid,
    output logic          res_pass,
    output logic [AW-1:0] res_addr,
    output logic          done,
    output logic          err_flag,
    output logic [AW-1:0] err_addr
);
    localparam int CW = $clog2(PULSE_CYC + SETUP_CYC + 2);
    localparam logic [CW-1:0] LIM_PULSE = CW'(PULSE_CYC);
    localparam logic [CW-1:0] LIM_SETUP = CW'(SETUP_CYC);
    localparam logic [CW-1:0] LIM_ONE   = CW'(1);

    seq_state_t    state, state_nxt;
    seq_op_t       op_q;
    logic          cont_q;
    logic [DW-1:0] data_q;
    logic          accept, tmr_exp, step, last, match, capture;
    logic [CW-1:0] limit;
    logic [DW-1:0] expect_byte;

    assign accept = start && (state == ST_IDLE || state == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    if (byte_count == '0)                     state_nxt = ST_DONE;
                    else if (seq_op_t'(op_mode) == OP_BLANK)  state_nxt = ST_RD_REL;
                    else                                      state_nxt = ST_LOAD;
                end
            end
            ST_LOAD:
                if (in_valid) state_nxt = (op_q == OP_VERIFY) ? ST_RD_REL : ST_ADDR_SET;
            ST_ADDR_SET: if (tmr_exp) state_nxt = ST_VPP_UP;
            ST_VPP_UP:   if (tmr_exp) state_nxt = ST_PULSE;
            ST_PULSE:    if (tmr_exp) state_nxt = ST_VPP_HOLD;
            ST_VPP_HOLD: if (tmr_exp) state_nxt = ST_VPP_DOWN;
            ST_VPP_DOWN: begin
                if (tmr_exp) begin
                    if (op_q == OP_PROG_ONLY) state_nxt = last ? ST_DONE : ST_LOAD;
                    else                      state_nxt = ST_RD_REL;
                end
            end
            ST_RD_REL:  if (tmr_exp) state_nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (tmr_exp) state_nxt = ST_CHECK;
            ST_CHECK: begin
                if ((!match && !cont_q) || last) state_nxt = ST_DONE;
                else if (op_q == OP_BLANK)       state_nxt = ST_RD_REL;
                else                             state_nxt = ST_LOAD;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        mode_en     = 1'b1;
        mem_dout_en = 1'b0;
        vpp_en      = 1'b0;
        prog_n      = 1'b1;
        oe_n        = 1'b1;
        in_ready    = 1'b0;
        res_valid   = 1'b0;
        done        = 1'b0;
        limit       = LIM_ONE;
        unique case (state)
            ST_IDLE:     mode_en = 1'b0;
            ST_DONE:     begin mode_en = 1'b0; done = 1'b1; end
            ST_LOAD:     in_ready = 1'b1;
            ST_ADDR_SET: begin mem_dout_en = 1'b1; limit = LIM_SETUP; end
            ST_VPP_UP:   begin mem_dout_en = 1'b1; vpp_en = 1'b1; limit = LIM_SETUP; end
            ST_PULSE:    begin mem_dout_en = 1'b1; vpp_en = 1'b1; prog_n = 1'b0; limit = LIM_PULSE; end
            ST_VPP_HOLD: begin mem_dout_en = 1'b1; vpp_en = 1'b1; limit = LIM_SETUP; end
            ST_VPP_DOWN: begin mem_dout_en = 1'b1; limit = LIM_SETUP; end
            ST_RD_REL:   limit = LIM_SETUP;
            ST_RD_WAIT:  begin oe_n = 1'b0; limit = LIM_SETUP; end
            ST_CHECK:    res_valid = 1'b1;
            default:     mode_en = 1'b0;
        endcase
    end

    // run context and stream byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_PROG_VERIFY;
            cont_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= seq_op_t'(op_mode);
                cont_q <= cont_on_err;
            end
            if (state == ST_LOAD && in_valid) data_q <= in_data;
        end
    end

    // sticky error and first failing location
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (accept) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (state == ST_CHECK && !match && !err_flag) begin
            err_flag <= 1'b1;
            err_addr <= mem_addr;
        end
    end

    assign step = (state == ST_CHECK) ||
                  (state == ST_VPP_DOWN && tmr_exp && op_q == OP_PROG_ONLY);
    assign capture     = (state == ST_RD_WAIT) && tmr_exp;
    assign expect_byte = (op_q == OP_BLANK) ? {DW{1'b1}} : data_q;
    assign mem_dout    = data_q;
    assign res_pass    = match;
    assign res_addr    = mem_addr;

    eprom_step_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nxt != state),
        .limit   (limit),
        .expired (tmr_exp)
    );

    eprom_span_ctr #(.AW(AW)) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (step),
        .base  (base_addr),
        .count (byte_count),
        .addr  (mem_addr),
        .last  (last)
    );

    eprom_read_check #(.DW(DW)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .bus_in      (mem_din),
        .expect_byte (expect_byte),
        .match       (match)
    );
endmodule

// File: rtl/eprom_seq_chk.sv
module eprom_seq_chk #(
    parameter int AW        = 13,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 5000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dout,
    input logic          mem_dout_en,
    input logic          mode_en,
    input logic          vpp_en,
    input logic          prog_n,
    input logic          oe_n,
    input logic          in_ready,
    input logic          res_valid,
    input logic          res_pass,
    input logic          done,
    input logic          err_flag,
    input logic          cont_q
);
    localparam int LW = $clog2(PULSE_CYC + 2) + 1;

    logic [LW-1:0] plen;
    logic          pulsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       plen <= '0;
        else if (!prog_n) plen <= plen + 1'b1;
        else              plen <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pulsed <= 1'b0;
        else if (!vpp_en)                  pulsed <= 1'b0;
        else if (prog_n && plen != '0)     pulsed <= 1'b1;
    end

    a_r2_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (vpp_en && mem_dout_en && mode_en));

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n) |-> (plen == LW'(PULSE_CYC)));

    a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> !pulsed);

    a_r1_bus_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && $past(vpp_en)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    a_r1_vpp_edges: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vpp_en) || $fell(vpp_en)) |-> prog_n);

    a_r3_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !mem_dout_en);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !start) |=> err_flag);

    a_r8_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pass && !cont_q) |=> done);

    a_r4_result_alone: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!done && !in_ready && oe_n));
endmodule

bind eprom_pgm_seq eprom_seq_chk #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mode_en     (mode_en),
    .vpp_en      (vpp_en),
    .prog_n      (prog_n),
    .oe_n        (oe_n),
    .in_ready    (in_ready),
    .res_valid   (res_valid),
    .res_pass    (res_pass),
    .done        (done),
    .err_flag    (err_flag),
    .cont_q      (cont_q)
);

// File: tb/sim_eprom_pgm_seq.sv
module sim_eprom_pgm_seq;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int PULSE = 6;
    localparam int SETUP = 2;
    localparam int NLOC = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_mode = 2'b00;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   byte_count = '0;
    logic          cont_on_err = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;
    logic          mode_en, vpp_en, prog_n, oe_n;
    logic          res_valid, res_pass, done, err_flag;
    logic [AW-1:0] res_addr, err_addr;

    always #5 clk = ~clk;

    eprom_pgm_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP)) u0 (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural EPROM
    logic [DW-1:0] arr [NLOC];
    bit            bad [NLOC];
    always_comb begin
        if (!oe_n && !mem_dout_en)
            mem_din = arr[mem_addr] ^ (bad[mem_addr] ? 8'h01 : 8'h00);
        else
            mem_din = 8'h00;
    end

    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    logic          p_vpp = 1'b0, p_prog = 1'b1, p_oe = 1'b1;
    int stab = 0, vcnt = 0, pcnt = 0, plow = 0, rel = 0;
    int viol = 0, pulses = 0, oe_cyc = 0, rdy_cyc = 0, drop = 0, nres = 0;
    bit in_op = 1'b0;
    logic [AW-1:0] r_addr [64];
    bit            r_pass [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_addr != p_addr || mem_dout != p_dout) begin
                stab = 0;
                if (vpp_en && p_vpp) viol++;
            end else stab++;
            if (vpp_en && !p_vpp) begin
                if (stab < SETUP || !mem_dout_en || !prog_n) viol++;
                vcnt = 0;
            end else vcnt++;
            if (prog_n && !p_prog) begin
                if (plow != PULSE) viol++;
                arr[mem_addr] = arr[mem_addr] & mem_dout;
                pulses++;
                pcnt = 0;
            end else pcnt++;
            if (!prog_n && p_prog) begin
                if (vcnt < SETUP) viol++;
                plow = 0;
            end
            if (!prog_n) begin
                plow++;
                if (!vpp_en || !mem_dout_en || !mode_en) viol++;
            end
            if (!vpp_en && p_vpp && (pcnt < SETUP || !prog_n)) viol++;
            if (mem_dout_en) rel = 0; else rel++;
            if (!oe_n && p_oe && (rel <= SETUP || stab < SETUP)) viol++;
            if (!oe_n && mem_dout_en) viol++;
            if (in_op) begin
                if (!oe_n) oe_cyc++;
                if (in_ready) rdy_cyc++;
                if (!mode_en && !done) drop++;
                if (res_valid && nres < 64) begin
                    r_addr[nres] = res_addr;
                    r_pass[nres] = res_pass;
                    nres++;
                end
            end
            p_addr = mem_addr; p_dout = mem_dout;
            p_vpp = vpp_en; p_prog = prog_n; p_oe = oe_n;
        end
    end

    // stream driver
    logic [DW-1:0] src [64];
    int n_src = 0, s_idx = 0;
    bit take = 1'b0;
    always @(negedge clk) begin
        if (take) s_idx++;
        in_valid = in_op && (s_idx < n_src);
        in_data  = src[s_idx < 64 ? s_idx : 0];
        take = in_valid && in_ready;
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic run_op(input logic [1:0] m, input int base, input int cnt,
                          input bit cont, input bit poke);
        int t;
        pulses = 0; oe_cyc = 0; rdy_cyc = 0; drop = 0; nres = 0; viol = 0;
        s_idx = 0; take = 1'b0;
        @(negedge clk);
        op_mode = m; base_addr = AW'(base); byte_count = (AW+1)'(cnt);
        cont_on_err = cont; in_op = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (100) @(negedge clk);
            base_addr = AW'(7); byte_count = 1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R9 run ends", int'(done), 1);
        in_op = 1'b0;
    endtask

    initial begin
        int fails;
        for (int i = 0; i < NLOC; i++) begin arr[i] = 8'hFF; bad[i] = 1'b0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(prog_n && oe_n && !vpp_en && !mem_dout_en && !mode_en, "R10 strobes idle",
            int'({prog_n, oe_n, vpp_en, mem_dout_en, mode_en}), 5'b11000);
        chk(!in_ready && !res_valid && !done && !err_flag, "R10 status idle",
            int'({in_ready, res_valid, done, err_flag}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // blank check, whole array, R5 R11
        n_src = 0;
        run_op(2'b11, 0, NLOC, 1'b0, 1'b0);
        chk(nres == NLOC, "R4 blank result count", nres, NLOC);
        fails = 0;
        for (int i = 0; i < NLOC; i++)
            if (!r_pass[i] || r_addr[i] != AW'(i)) fails++;
        chk(fails == 0, "R6 blank order and pass", fails, 0);
        chk(rdy_cyc == 0, "R11 blank takes no stream", rdy_cyc, 0);
        chk(pulses == 0, "R5 blank no strobe", pulses, 0);
        chk(oe_cyc == NLOC * SETUP, "R3 oe length", oe_cyc, NLOC * SETUP);

        // program and verify whole array, with a start poke mid-run (R9)
        for (int i = 0; i < NLOC; i++) src[i] = pat(i);
        n_src = NLOC;
        run_op(2'b00, 0, NLOC, 1'b0, 1'b1);
        chk(pulses == NLOC, "R2 one pulse per byte", pulses, NLOC);
        chk(viol == 0, "R1 ordering and timing", viol, 0);
        chk(nres == NLOC, "R9 start ignored while busy", nres, NLOC);
        fails = 0;
        for (int i = 0; i < NLOC; i++) begin
            if (!r_pass[i] || r_addr[i] != AW'(i)) fails++;
            if (arr[i] != pat(i)) fails++;
        end
        chk(fails == 0, "R4 program verify results", fails, 0);
        chk(rdy_cyc == NLOC, "R11 one stream byte per location", rdy_cyc, NLOC);
        chk(drop == 0, "R12 mode_en held", drop, 0);
        chk(!err_flag, "R7 no error on clean run", int'(err_flag), 0);
        repeat (10) @(negedge clk);
        chk(done, "R9 done held", int'(done), 1);

        // verify-only pass over the same range
        run_op(2'b10, 0, NLOC, 1'b0, 1'b0);
        fails = 0;
        for (int i = 0; i < NLOC; i++) if (!r_pass[i]) fails++;
        chk(nres == NLOC && fails == 0, "R5 verify mode passes", fails, 0);
        chk(pulses == 0, "R5 verify no strobe", pulses, 0);
        chk(viol == 0, "R3 verify timing", viol, 0);

        // blank check on programmed range, stop on first failure
        n_src = 0;
        run_op(2'b11, 4, 5, 1'b0, 1'b0);
        chk(nres == 1 && !r_pass[0], "R8 stop after first fail", nres, 1);
        chk(err_flag && err_addr == 4, "R7 first failing address", int'(err_addr), 4);

        // program only, data zero
        for (int i = 0; i < 3; i++) src[i] = 8'h00;
        n_src = 3;
        run_op(2'b01, 0, 3, 1'b0, 1'b0);
        chk(oe_cyc == 0 && nres == 0, "R5 program only no read", oe_cyc + nres, 0);
        chk(pulses == 3, "R2 program only pulses", pulses, 3);
        chk(arr[0] == 0 && arr[1] == 0 && arr[2] == 0, "R5 program only wrote", int'(arr[1]), 0);
        chk(!err_flag, "R7 cleared by start", int'(err_flag), 0);

        // wrap with two read faults, continue on error
        bad[29] = 1'b1; bad[1] = 1'b1;
        for (int i = 0; i < 8; i++) src[i] = 8'h00;
        n_src = 8;
        run_op(2'b00, 28, 8, 1'b1, 1'b0);
        chk(nres == 8, "R8 continue processes all", nres, 8);
        fails = 0;
        for (int i = 0; i < 8; i++) begin
            if (r_addr[i] != AW'(28 + i)) fails++;
            if (r_pass[i] != !(i == 1 || i == 5)) fails++;
        end
        chk(fails == 0, "R6 wrap order and fail pattern", fails, 0);
        chk(err_flag && err_addr == 29, "R7 keeps first failure", int'(err_addr), 29);
        bad[29] = 1'b0; bad[1] = 1'b0;

        // fail on the last byte, stop and continue
        bad[31] = 1'b1;
        for (int c = 0; c < 2; c++) begin
            n_src = 2;
            run_op(2'b00, 30, 2, c[0], 1'b0);
            chk(nres == 2 && r_pass[0] && !r_pass[1], "R8 last byte fail", nres, 2);
            chk(pulses == 2, "R2 no extra pulse after last fail", pulses, 2);
            chk(err_addr == 31, "R7 last address recorded", int'(err_addr), 31);
        end
        bad[31] = 1'b0;

        // zero count
        n_src = 0;
        run_op(2'b00, 9, 0, 1'b0, 1'b0);
        chk(nres == 0 && pulses == 0 && rdy_cyc == 0, "R6 zero count idle", nres + pulses, 0);

        // clean verify clears the error
        src[0] = 8'h00; n_src = 1;
        run_op(2'b10, 0, 1, 1'b0, 1'b0);
        chk(nres == 1 && r_pass[0] && !err_flag, "R7 cleared on clean run", int'(err_flag), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule